// File: doc/BRIEF.md
# Trace Cache Hit and Next-Fetch Selection

This block sits in the fetch stage of a wide front end. It holds a small direct-mapped array of trace lines. Each line describes a recorded dynamic path of up to `MAX_INSN` instructions that crosses up to `MAX_BR` conditional branches. Every cycle in which the fetch stage presents an address, the block reads the line that address selects. It compares the line's start address with the fetch address and checks the directions recorded in the trace against the per-branch predictions of a multiple-branch predictor. One cycle later it reports whether the trace can supply instructions, how many, and where fetch continues.

A line stores the following:
- its start address;
- the number of branches it contains;
- whether its last instruction is a branch;
- the recorded direction of each branch;
- the instruction count up to and including each branch;
- the total instruction count;
- the address that follows a not-taken final branch (the fall-through address);
- the address that follows a taken final branch (the taken address);
- for each branch, the address on the path that was not recorded.

When a prediction disagrees with the recorded path, the line still supplies its instructions up to that branch, and fetch moves to the predicted side. On a miss, the fetch address is handed straight back as the next fetch address, so the conventional instruction path can serve it. Lines are written through a plain write port driven by the trace builder.

Top module: `trace_hit_unit`

## Requirements
- R1: After reset, `out_valid`, `out_hit`, `out_miss` and `out_partial` are low, `out_count` and `out_next_addr` are zero, and every line is invalid, so any lookup misses until a line is written.
- R2: A lookup presented with `fetch_valid` high produces its result with `out_valid` high on the next clock edge; without `fetch_valid`, `out_valid` and all flags are low in the following cycle.
- R3: If the selected line is invalid or its stored start address differs from `fetch_addr`, the result is a miss: `out_miss`=1, `out_hit`=0, `out_count`=0 and `out_next_addr` equals `fetch_addr`.
- R4: On a full match of a line whose last instruction is not a branch (`wr_ends_br`=0), `out_count` is the line's total count and `out_next_addr` is its fall-through address.
- R5: On a full match of a line that ends in a branch (`wr_ends_br`=1 and `wr_br_cnt`≥1), the final branch is number `wr_br_cnt`-1. If `pred_taken` bit `wr_br_cnt`-1 is 1, the next address is the taken address; otherwise it is the fall-through address. The count is the total count.
- R6: Only internal branches are compared: branch numbers below `wr_br_cnt`, minus the final branch when the line ends in a branch. Prediction bits at or above that limit have no effect on any output. Bit i of `pred_taken` and of `wr_br_dir` refers to branch i in trace order, and 1 means taken.
- R7: If internal branch k is the lowest-numbered branch whose prediction differs from its recorded direction, the result is a partial hit. `out_hit`=1, `out_partial`=1, `out_count` is the count through branch k (field k of `wr_br_pos`, bits `k*CNT_W +: CNT_W`), and `out_next_addr` is the alternate address of branch k (bits `k*AW +: AW` of `wr_alt_addr`).
- R8: `wr_en` stores a line at index `wr_start_addr mod NUM_LINES` and replaces whatever was there. A lookup in the same cycle as a write sees the contents from before the write.
- R9: A line with zero branches matches whatever the predictions are, and supplies its total count with the fall-through address as next fetch.
- R10: `out_hit` and `out_miss` are never high together, and `out_partial` is low on full hits and on misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A lookup is presented this cycle |
| fetch_addr | input | AW | Fetch address (instruction-word address) |
| pred_taken | input | MAX_BR | Per-branch predicted directions, bit i = branch i, 1 = taken |
| wr_en | input | 1 | Write a line |
| wr_start_addr | input | AW | Start address of the written line; its low bits select the index |
| wr_br_cnt | input | BRC_W | Number of branches in the line |
| wr_ends_br | input | 1 | Last instruction of the line is a branch |
| wr_br_dir | input | MAX_BR | Recorded direction of each branch, 1 = taken |
| wr_br_pos | input | MAX_BR*CNT_W | Per-branch instruction count through that branch |
| wr_n_insn | input | CNT_W | Total instructions in the line (1..MAX_INSN) |
| wr_fall_addr | input | AW | Fall-through address after the line |
| wr_taken_addr | input | AW | Address after a taken final branch |
| wr_alt_addr | input | MAX_BR*AW | Per-branch address of the unrecorded direction |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | Trace supplies instructions (full or partial) |
| out_miss | output | 1 | Lookup missed; fetch falls back to the normal path |
| out_partial | output | 1 | Hit stopped early at a disagreeing branch |
| out_count | output | CNT_W | Number of instructions supplied |
| out_next_addr | output | AW | Next fetch address |

## Verification
The bench builds the block with four lines, a 12-bit address and the default three branches and sixteen instructions. The small array makes index aliasing and line replacement frequent. Random lookups are drawn from a handful of start addresses that collide on the same index, which covers misses caused by a stale tag as well as hits. With three branches, every placement of the first disagreeing branch and every combination of final-branch outcome and ignored prediction bits is reached, both in directed cases and in random ones.

// File: rtl/tch_pkg.sv
package tch_pkg;
  typedef enum logic [1:0] {
    LK_MISS = 2'd0,
    LK_FULL = 2'd1,
    LK_PART = 2'd2
  } lookup_kind_e;
endpackage

// File: rtl/tch_line_store.sv
module tch_line_store #(
  parameter int NUM_LINES = 16,
  parameter int AW        = 32,
  parameter int MAX_BR    = 3,
  parameter int CNT_W     = 5,
  parameter int BRC_W     = 2,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_start_addr,
  input  logic [BRC_W-1:0]        wr_br_cnt,
  input  logic                    wr_ends_br,
  input  logic [MAX_BR-1:0]       wr_br_dir,
  input  logic [MAX_BR*CNT_W-1:0] wr_br_pos,
  input  logic [CNT_W-1:0]        wr_n_insn,
  input  logic [AW-1:0]           wr_fall_addr,
  input  logic [AW-1:0]           wr_taken_addr,
  input  logic [MAX_BR*AW-1:0]    wr_alt_addr,
  input  logic [AW-1:0]           rd_addr,
  output logic                    rd_valid,
  output logic [AW-1:0]           rd_tag,
  output logic [BRC_W-1:0]        rd_br_cnt,
  output logic                    rd_ends_br,
  output logic [MAX_BR-1:0]       rd_br_dir,
  output logic [MAX_BR*CNT_W-1:0] rd_br_pos,
  output logic [CNT_W-1:0]        rd_n_insn,
  output logic [AW-1:0]           rd_fall_addr,
  output logic [AW-1:0]           rd_taken_addr,
  output logic [MAX_BR*AW-1:0]    rd_alt_addr
);
  logic [NUM_LINES-1:0]    valid_q;
  logic [AW-1:0]           tag_q   [NUM_LINES];
  logic [BRC_W-1:0]        cnt_q   [NUM_LINES];
  logic                    ends_q  [NUM_LINES];
  logic [MAX_BR-1:0]       dir_q   [NUM_LINES];
  logic [MAX_BR*CNT_W-1:0] pos_q   [NUM_LINES];
  logic [CNT_W-1:0]        ninsn_q [NUM_LINES];
  logic [AW-1:0]           fall_q  [NUM_LINES];
  logic [AW-1:0]           taken_q [NUM_LINES];
  logic [MAX_BR*AW-1:0]    alt_q   [NUM_LINES];

  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  assign wr_idx = wr_start_addr[IDX_W-1:0];
  assign rd_idx = rd_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]   <= wr_start_addr;
      cnt_q[wr_idx]   <= wr_br_cnt;
      ends_q[wr_idx]  <= wr_ends_br;
      dir_q[wr_idx]   <= wr_br_dir;
      pos_q[wr_idx]   <= wr_br_pos;
      ninsn_q[wr_idx] <= wr_n_insn;
      fall_q[wr_idx]  <= wr_fall_addr;
      taken_q[wr_idx] <= wr_taken_addr;
      alt_q[wr_idx]   <= wr_alt_addr;
    end
  end

  assign rd_valid      = valid_q[rd_idx];
  assign rd_tag        = tag_q[rd_idx];
  assign rd_br_cnt     = cnt_q[rd_idx];
  assign rd_ends_br    = ends_q[rd_idx];
  assign rd_br_dir     = dir_q[rd_idx];
  assign rd_br_pos     = pos_q[rd_idx];
  assign rd_n_insn     = ninsn_q[rd_idx];
  assign rd_fall_addr  = fall_q[rd_idx];
  assign rd_taken_addr = taken_q[rd_idx];
  assign rd_alt_addr   = alt_q[rd_idx];
endmodule

// File: rtl/tch_match.sv
module tch_match
  import tch_pkg::*;
#(
  parameter int AW     = 32,
  parameter int MAX_BR = 3,
  parameter int CNT_W  = 5,
  parameter int BRC_W  = 2
) (
  input  logic [AW-1:0]           fetch_addr,
  input  logic [MAX_BR-1:0]       pred_taken,
  input  logic                    ln_valid,
  input  logic [AW-1:0]           ln_tag,
  input  logic [BRC_W-1:0]        ln_br_cnt,
  input  logic                    ln_ends_br,
  input  logic [MAX_BR-1:0]       ln_br_dir,
  input  logic [MAX_BR*CNT_W-1:0] ln_br_pos,
  input  logic [CNT_W-1:0]        ln_n_insn,
  input  logic [AW-1:0]           ln_fall_addr,
  input  logic [AW-1:0]           ln_taken_addr,
  input  logic [MAX_BR*AW-1:0]    ln_alt_addr,
  output lookup_kind_e            kind,
  output logic [CNT_W-1:0]        count,
  output logic [AW-1:0]           next_addr,
  output logic                    tag_match,
  output logic                    term_taken,
  output logic [BRC_W-1:0]        first_bad
);
  // Number of branches whose recorded direction must match the predictions.
  function automatic logic [BRC_W-1:0] inner_branches(input logic [BRC_W-1:0] n,
                                                      input logic ends);
    if (ends && n != '0) return n - 1'b1;
    return n;
  endfunction

  // Lowest-numbered internal branch that disagrees; MAX_BR if none does.
  function automatic logic [BRC_W-1:0] lowest_disagree(input logic [MAX_BR-1:0] dir,
                                                       input logic [MAX_BR-1:0] pred,
                                                       input logic [BRC_W-1:0] limit);
    logic [BRC_W-1:0] res;
    res = BRC_W'(MAX_BR);
    for (int i = MAX_BR - 1; i >= 0; i--) begin
      if (BRC_W'(i) < limit && dir[i] != pred[i]) res = BRC_W'(i);
    end
    return res;
  endfunction

  logic [BRC_W-1:0] n_inner;
  logic             has_term;

  assign tag_match = ln_valid && (ln_tag == fetch_addr);
  assign has_term  = ln_ends_br && (ln_br_cnt != '0);
  assign n_inner   = inner_branches(ln_br_cnt, ln_ends_br);
  assign first_bad = lowest_disagree(ln_br_dir, pred_taken, n_inner);
  assign term_taken = has_term && pred_taken[ln_br_cnt - 1'b1];

  always_comb begin
    kind      = LK_MISS;
    count     = '0;
    next_addr = fetch_addr;
    if (tag_match) begin
      if (first_bad != BRC_W'(MAX_BR)) begin
        kind      = LK_PART;
        count     = ln_br_pos[first_bad*CNT_W +: CNT_W];
        next_addr = ln_alt_addr[first_bad*AW +: AW];
      end else begin
        kind      = LK_FULL;
        count     = ln_n_insn;
        next_addr = term_taken ? ln_taken_addr : ln_fall_addr;
      end
    end
  end
endmodule

// File: rtl/trace_hit_unit.sv
module trace_hit_unit
  import tch_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int AW        = 32,
  parameter int MAX_BR    = 3,
  parameter int MAX_INSN  = 16,
  localparam int CNT_W    = $clog2(MAX_INSN + 1),
  localparam int BRC_W    = $clog2(MAX_BR + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_valid,
  input  logic [AW-1:0]           fetch_addr,
  input  logic [MAX_BR-1:0]       pred_taken,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_start_addr,
  input  logic [BRC_W-1:0]        wr_br_cnt,
  input  logic                    wr_ends_br,
  input  logic [MAX_BR-1:0]       wr_br_dir,
  input  logic [MAX_BR*CNT_W-1:0] wr_br_pos,
  input  logic [CNT_W-1:0]        wr_n_insn,
  input  logic [AW-1:0]           wr_fall_addr,
  input  logic [AW-1:0]           wr_taken_addr,
  input  logic [MAX_BR*AW-1:0]    wr_alt_addr,
  output logic                    out_valid,
  output logic                    out_hit,
  output logic                    out_miss,
  output logic                    out_partial,
  output logic [CNT_W-1:0]        out_count,
  output logic [AW-1:0]           out_next_addr
);
  logic                    ln_valid;
  logic [AW-1:0]           ln_tag;
  logic [BRC_W-1:0]        ln_br_cnt;
  logic                    ln_ends_br;
  logic [MAX_BR-1:0]       ln_br_dir;
  logic [MAX_BR*CNT_W-1:0] ln_br_pos;
  logic [CNT_W-1:0]        ln_n_insn;
  logic [AW-1:0]           ln_fall_addr;
  logic [AW-1:0]           ln_taken_addr;
  logic [MAX_BR*AW-1:0]    ln_alt_addr;

  lookup_kind_e     mt_kind;
  logic [CNT_W-1:0] mt_count;
  logic [AW-1:0]    mt_next;
  logic             mt_tag_match;
  logic             mt_term_taken;
  logic [BRC_W-1:0] mt_first_bad;

  tch_line_store #(
    .NUM_LINES(NUM_LINES), .AW(AW), .MAX_BR(MAX_BR), .CNT_W(CNT_W), .BRC_W(BRC_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_start_addr(wr_start_addr), .wr_br_cnt(wr_br_cnt),
    .wr_ends_br(wr_ends_br), .wr_br_dir(wr_br_dir), .wr_br_pos(wr_br_pos),
    .wr_n_insn(wr_n_insn), .wr_fall_addr(wr_fall_addr),
    .wr_taken_addr(wr_taken_addr), .wr_alt_addr(wr_alt_addr),
    .rd_addr(fetch_addr),
    .rd_valid(ln_valid), .rd_tag(ln_tag), .rd_br_cnt(ln_br_cnt),
    .rd_ends_br(ln_ends_br), .rd_br_dir(ln_br_dir), .rd_br_pos(ln_br_pos),
    .rd_n_insn(ln_n_insn), .rd_fall_addr(ln_fall_addr),
    .rd_taken_addr(ln_taken_addr), .rd_alt_addr(ln_alt_addr)
  );

  tch_match #(
    .AW(AW), .MAX_BR(MAX_BR), .CNT_W(CNT_W), .BRC_W(BRC_W)
  ) u_match (
    .fetch_addr(fetch_addr), .pred_taken(pred_taken),
    .ln_valid(ln_valid), .ln_tag(ln_tag), .ln_br_cnt(ln_br_cnt),
    .ln_ends_br(ln_ends_br), .ln_br_dir(ln_br_dir), .ln_br_pos(ln_br_pos),
    .ln_n_insn(ln_n_insn), .ln_fall_addr(ln_fall_addr),
    .ln_taken_addr(ln_taken_addr), .ln_alt_addr(ln_alt_addr),
    .kind(mt_kind), .count(mt_count), .next_addr(mt_next),
    .tag_match(mt_tag_match), .term_taken(mt_term_taken),
    .first_bad(mt_first_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_hit       <= 1'b0;
      out_miss      <= 1'b0;
      out_partial   <= 1'b0;
      out_count     <= '0;
      out_next_addr <= '0;
    end else begin
      out_valid     <= fetch_valid;
      out_hit       <= fetch_valid && (mt_kind != LK_MISS);
      out_miss      <= fetch_valid && (mt_kind == LK_MISS);
      out_partial   <= fetch_valid && (mt_kind == LK_PART);
      out_count     <= fetch_valid ? mt_count : '0;
      out_next_addr <= fetch_valid ? mt_next : '0;
    end
  end
endmodule

// File: rtl/tch_checker.sv
module tch_checker #(
  parameter int AW       = 32,
  parameter int CNT_W    = 5,
  parameter int MAX_INSN = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic [AW-1:0]    fetch_addr,
  input logic             out_valid,
  input logic             out_hit,
  input logic             out_miss,
  input logic             out_partial,
  input logic [CNT_W-1:0] out_count,
  input logic [AW-1:0]    out_next_addr
);
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> (!out_valid && !out_hit && !out_miss && !out_partial));

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != out_miss));

  p_partial_is_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_partial |-> out_hit);

  p_miss_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> (out_miss |-> (out_next_addr == $past(fetch_addr) && out_count == '0)));

  p_hit_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> (out_count >= CNT_W'(1) && out_count <= CNT_W'(MAX_INSN)));
endmodule

bind trace_hit_unit tch_checker #(.AW(AW), .CNT_W(CNT_W), .MAX_INSN(MAX_INSN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
  .out_partial(out_partial), .out_count(out_count), .out_next_addr(out_next_addr)
);

// File: tb/trace_hit_unit_bench.sv
module trace_hit_unit_bench;
  localparam int NL = 4;
  localparam int AW = 12;
  localparam int MB = 3;
  localparam int MI = 16;
  localparam int CW = $clog2(MI + 1);
  localparam int BW = $clog2(MB + 1);

  typedef struct {
    bit v;
    int start;
    int nbr;
    bit ends;
    bit dir [MB];
    int pos [MB];
    int ninsn;
    int fall;
    int taken;
    int alt [MB];
  } tline_t;

  logic clk = 0;
  logic rst_n = 0;
  logic fetch_valid = 0;
  logic [AW-1:0] fetch_addr = '0;
  logic [MB-1:0] pred_taken = '0;
  logic wr_en = 0;
  logic [AW-1:0] wr_start_addr = '0;
  logic [BW-1:0] wr_br_cnt = '0;
  logic wr_ends_br = 0;
  logic [MB-1:0] wr_br_dir = '0;
  logic [MB*CW-1:0] wr_br_pos = '0;
  logic [CW-1:0] wr_n_insn = '0;
  logic [AW-1:0] wr_fall_addr = '0;
  logic [AW-1:0] wr_taken_addr = '0;
  logic [MB*AW-1:0] wr_alt_addr = '0;
  logic out_valid, out_hit, out_miss, out_partial;
  logic [CW-1:0] out_count;
  logic [AW-1:0] out_next_addr;

  always #2.5 clk = ~clk;

  trace_hit_unit #(.NUM_LINES(NL), .AW(AW), .MAX_BR(MB), .MAX_INSN(MI)) u_trace_hit_unit (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .pred_taken(pred_taken), .wr_en(wr_en), .wr_start_addr(wr_start_addr),
    .wr_br_cnt(wr_br_cnt), .wr_ends_br(wr_ends_br), .wr_br_dir(wr_br_dir),
    .wr_br_pos(wr_br_pos), .wr_n_insn(wr_n_insn), .wr_fall_addr(wr_fall_addr),
    .wr_taken_addr(wr_taken_addr), .wr_alt_addr(wr_alt_addr),
    .out_valid(out_valid), .out_hit(out_hit), .out_miss(out_miss),
    .out_partial(out_partial), .out_count(out_count), .out_next_addr(out_next_addr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  tline_t model [int];

  bit    pend = 0;
  bit    e_valid, e_hit, e_miss, e_part;
  int    e_cnt, e_next;
  string e_req;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected result from the requirements; returns the requirement that governs it.
  function automatic string predict(input int fa, input bit [MB-1:0] pr,
                                    output bit h, output bit m, output bit p,
                                    output int c, output int nx);
    tline_t t;
    int idx = fa % NL;
    int inner;
    bit term;
    h = 0; m = 1; p = 0; c = 0; nx = fa;
    if (!model.exists(idx)) return "R1/R3";
    t = model[idx];
    if (!t.v || t.start != fa) return "R3";
    h = 1; m = 0;
    term = t.ends && t.nbr > 0;
    inner = term ? t.nbr - 1 : t.nbr;
    for (int j = 0; j < inner; j++) begin
      if (pr[j] != t.dir[j]) begin
        p = 1; c = t.pos[j]; nx = t.alt[j];
        return "R7";
      end
    end
    c = t.ninsn;
    if (term) begin
      nx = pr[t.nbr-1] ? t.taken : t.fall;
      return "R5";
    end
    nx = t.fall;
    return (t.nbr == 0) ? "R9" : "R4";
  endfunction

  task automatic compare_pending();
    if (!pend) return;
    chk(e_req, "out_valid", out_valid, e_valid);
    chk(e_req, "out_hit", out_hit, e_hit);
    chk(e_req, "out_miss", out_miss, e_miss);
    chk(e_req, "out_partial", out_partial, e_part);
    if (e_valid) begin
      chk(e_req, "out_count", out_count, e_cnt);
      chk(e_req, "out_next_addr", out_next_addr, e_next);
    end
  endtask

  // One cycle: compare last result, drive new inputs, predict, then update model.
  task automatic step(input bit fv, input int fa, input bit [MB-1:0] pr,
                      input bit we, input tline_t wl, input string tag);
    string r;
    @(negedge clk);
    compare_pending();
    fetch_valid = fv;
    fetch_addr  = AW'(fa);
    pred_taken  = pr;
    wr_en       = we;
    wr_start_addr = AW'(wl.start);
    wr_br_cnt     = BW'(wl.nbr);
    wr_ends_br    = wl.ends;
    wr_n_insn     = CW'(wl.ninsn);
    wr_fall_addr  = AW'(wl.fall);
    wr_taken_addr = AW'(wl.taken);
    for (int j = 0; j < MB; j++) begin
      wr_br_dir[j] = wl.dir[j];
      wr_br_pos[j*CW +: CW] = CW'(wl.pos[j]);
      wr_alt_addr[j*AW +: AW] = AW'(wl.alt[j]);
    end
    r = predict(fa, pr, e_hit, e_miss, e_part, e_cnt, e_next);
    e_valid = fv;
    if (!fv) begin
      e_hit = 0; e_miss = 0; e_part = 0; r = "R2";
    end
    e_req = (tag != "") ? tag : r;
    pend = 1;
    if (we) model[wl.start % NL] = wl;
  endtask

  function automatic tline_t mk(input int st, input int nb, input bit en, input bit [MB-1:0] d,
                                input int p0, input int p1, input int p2, input int n,
                                input int fl, input int tk, input int a0, input int a1, input int a2);
    tline_t t;
    t.v = 1; t.start = st; t.nbr = nb; t.ends = en;
    for (int j = 0; j < MB; j++) t.dir[j] = d[j];
    t.pos[0] = p0; t.pos[1] = p1; t.pos[2] = p2;
    t.ninsn = n; t.fall = fl; t.taken = tk;
    t.alt[0] = a0; t.alt[1] = a1; t.alt[2] = a2;
    return t;
  endfunction

  function automatic tline_t rnd_line(input int st);
    tline_t t;
    int prev;
    t.v = 1; t.start = st;
    t.nbr = $urandom_range(0, MB);
    t.ends = $urandom_range(0, 1);
    t.ninsn = $urandom_range(t.nbr + 1, MI);
    prev = 0;
    for (int j = 0; j < MB; j++) begin
      t.dir[j] = $urandom_range(0, 1);
      t.alt[j] = $urandom_range(0, (1 << AW) - 1);
      if (j < t.nbr) begin
        t.pos[j] = $urandom_range(prev + 1, t.ninsn - (t.nbr - 1 - j));
        prev = t.pos[j];
      end else t.pos[j] = 0;
    end
    if (t.ends && t.nbr > 0) t.ninsn = t.pos[t.nbr-1];
    t.fall  = $urandom_range(0, (1 << AW) - 1);
    t.taken = $urandom_range(0, (1 << AW) - 1);
    return t;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    tline_t none, la, lb, lc, ld;
    none = mk(0, 0, 0, '0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    none.v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "out_hit", out_hit, 0);
    chk("R1", "out_miss", out_miss, 0);
    chk("R1", "out_count", out_count, 0);
    chk("R1", "out_next_addr", out_next_addr, 0);
    rst_n = 1;
    step(1, 'h010, 3'b000, 0, none, "R1");
    step(1, 'h023, 3'b111, 0, none, "R1");
    // three branches, final one terminal, recorded b0 taken, b1 not taken
    la = mk('h021, 3, 1, 3'b001, 4, 9, 14, 14, 'h300, 'h400, 'h111, 'h222, 'h333);
    step(1, 'h021, 3'b101, 1, la, "R8");
    step(1, 'h021, 3'b101, 0, none, "R5");
    step(1, 'h021, 3'b001, 0, none, "R5");
    step(1, 'h021, 3'b000, 0, none, "R7");
    step(1, 'h021, 3'b011, 0, none, "R7");
    step(1, 'h021, 3'b010, 0, none, "R7");
    step(0, 'h021, 3'b101, 0, none, "R2");
    // two internal branches, no terminal branch
    lb = mk('h032, 2, 0, 3'b011, 3, 7, 0, 12, 'h500, 'h600, 'h0aa, 'h0bb, 'h0cc);
    step(1, 'h010, 3'b000, 1, lb, "R3");
    step(1, 'h032, 3'b011, 0, none, "R4");
    step(1, 'h032, 3'b111, 0, none, "R6");
    step(1, 'h032, 3'b001, 0, none, "R7");
    // no branches at all
    lc = mk('h043, 0, 0, 3'b000, 0, 0, 0, 16, 'h700, 'h7ff, 0, 0, 0);
    step(1, 'h043, 3'b000, 1, lc, "R8");
    step(1, 'h043, 3'b101, 0, none, "R9");
    step(1, 'h043, 3'b010, 0, none, "R9");
    // one branch, terminal: no internal comparisons at all
    ld = mk('h054, 1, 1, 3'b000, 6, 0, 0, 6, 'h800, 'h900, 'h111, 0, 0);
    step(1, 'h054, 3'b000, 1, ld, "");
    step(1, 'h054, 3'b111, 0, none, "R6");
    step(1, 'h054, 3'b110, 0, none, "R6");
    // aliasing and replacement on index 1
    step(1, 'h025, 3'b101, 0, none, "R3");
    la.start = 'h025;
    step(1, 'h025, 3'b101, 1, la, "R8");
    step(1, 'h021, 3'b101, 0, none, "R8");
    step(1, 'h025, 3'b101, 0, none, "R8");
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int base;
      int fa;
      bit we;
      base = $urandom_range(0, 7) * 4 + 'h100;
      fa = base + $urandom_range(0, NL - 1);
      we = ($urandom_range(0, 3) == 0);
      step($urandom_range(0, 7) != 0, fa, MB'($urandom_range(0, 7)), we,
           we ? rnd_line(base + $urandom_range(0, NL - 1)) : none, "");
    end
    step(0, 0, '0, 0, none, "R2");
    @(negedge clk);
    compare_pending();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule